// File: doc/BRIEF.md
# Saturating Add/Subtract Execution Unit

This unit is one execution slot of a processor datapath that performs 32-bit signed arithmetic and clamps the result instead of letting it wrap. It receives the instruction word, the two operand values already read from the register file, and a condition-pass bit from the flag logic. It returns a result, a write enable and a destination index one cycle later. It also holds a sticky saturation flag that stands for one bit of the status word.

Four operations are selected by two instruction bits. There is a plain saturating add and a plain saturating subtract. There are also two doubling forms: these first double the second operand, clamp that doubled value, and then add it to or subtract it from the first operand with a second clamp. A clamp at either step sets the sticky flag. The flag stays set until reset or until an explicit clear from a software write to the status word.

Top module: `sat_alu`

## Requirements
- R1: The operation is taken from `instr[22:21]`. Code 2'b00 returns the saturating sum `opnd_a + opnd_b`.
- R2: Code 2'b01 returns the saturating difference `opnd_a - opnd_b`.
- R3: Code 2'b10 first forms `2*opnd_b`, clamped to the 32-bit signed range. It then returns the saturating sum of `opnd_a` and that clamped value.
- R4: Code 2'b11 forms the clamped `2*opnd_b` in the same way and returns the saturating difference `opnd_a` minus that value.
- R5: When a step overflows, the value is clamped. A true result above the range becomes 0x7FFFFFFF and a true result below the range becomes 0x80000000. A result that fits is returned exact.
- R6: Any clamp in an executed operation sets `q_flag`, whether it happens on the doubling step or on the final step. A later operation that does not saturate leaves `q_flag` set.
- R7: The condition code is `instr[31:28]`. Code 4'hE always executes. Every other code executes only when `cond_pass` is 1.
- R8: An operation that does not execute gives `wr_en` = 0. It leaves `q_flag` unchanged and `result` holding its previous value.
- R9: For every cycle with `in_valid` = 1, the next cycle shows `out_valid` = 1, the write enable, `rd_idx` equal to `instr[15:12]` and the new result. A cycle without `in_valid` gives `out_valid` = 0 and `wr_en` = 0 next cycle.
- R10: A synchronous active-high `rst` clears `out_valid`, `wr_en`, `result` and `q_flag`.
- R11: `flag_clr` clears `q_flag` on the next edge. If an executed operation saturates in the same cycle, `q_flag` ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction and operands are present |
| instr | input | 32 | Instruction word: condition, operation code, destination |
| opnd_a | input | 32 | First operand |
| opnd_b | input | 32 | Second operand; this is the one doubled |
| cond_pass | input | 1 | Condition evaluation result from the flag logic |
| flag_clr | input | 1 | Clears the sticky saturation flag |
| out_valid | output | 1 | Registered result slot is valid |
| wr_en | output | 1 | Destination register write enable |
| rd_idx | output | 4 | Destination register index |
| result | output | 32 | Clamped result |
| q_flag | output | 1 | Sticky saturation flag |

## Verification
On every cycle, the assertions check four things. The output slot must follow its input one cycle later. A write may only come from an executed operation. The flag may never fall except through reset or the clear input. The flag may never rise without an executed operation behind it, and a skipped operation must leave it and the result unchanged. Whether a clamped value is correct can only be shown by the bench's scenarios. The bench compares each result against a wide-integer reference, over operand corners such as 0x7FFFFFFF, 0x80000000, 0 and -1. The same applies to the double clamp of the doubling forms and to the ordering of clear against a new saturation.

// File: rtl/sat_alu.sv
module sat_alu #(
  parameter int W = 32,
  parameter logic [3:0] CC_ALWAYS = 4'hE
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         in_valid,
  input  logic [31:0]  instr,
  input  logic [W-1:0] opnd_a,
  input  logic [W-1:0] opnd_b,
  input  logic         cond_pass,
  input  logic         flag_clr,
  output logic         out_valid,
  output logic         wr_en,
  output logic [3:0]   rd_idx,
  output logic [W-1:0] result,
  output logic         q_flag
);
  localparam int S = W - 1;
  localparam logic [W-1:0] MAXV = {1'b0, {S{1'b1}}};
  localparam logic [W-1:0] MINV = {1'b1, {S{1'b0}}};

  logic [1:0]   op;
  logic         exec;
  logic [W-1:0] dbl_raw, dbl_sat, rhs, raw, fin;
  logic         dbl_ovf, fin_ovf, sat_evt;

  assign op   = instr[22:21];
  assign exec = (instr[31:28] == CC_ALWAYS) || cond_pass;

  assign dbl_raw = opnd_b << 1;
  assign dbl_ovf = op[1] && (dbl_raw[S] != opnd_b[S]);
  assign dbl_sat = dbl_ovf ? (dbl_raw[S] ? MAXV : MINV) : dbl_raw;
  assign rhs     = op[1] ? dbl_sat : opnd_b;

  assign raw = op[0] ? (opnd_a - rhs) : (opnd_a + rhs);

  always_comb begin
    if (op[0])
      fin_ovf = (opnd_a[S] != rhs[S]) && (raw[S] != opnd_a[S]);
    else
      fin_ovf = (opnd_a[S] == rhs[S]) && (raw[S] != opnd_a[S]);
  end

  assign fin     = fin_ovf ? (raw[S] ? MAXV : MINV) : raw;
  assign sat_evt = dbl_ovf || fin_ovf;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      wr_en     <= 1'b0;
      rd_idx    <= '0;
      result    <= '0;
      q_flag    <= 1'b0;
    end else begin
      out_valid <= in_valid;
      wr_en     <= in_valid && exec;
      if (in_valid) rd_idx <= instr[15:12];
      if (in_valid && exec) result <= fin;
      if (in_valid && exec && sat_evt) q_flag <= 1'b1;
      else if (flag_clr)               q_flag <= 1'b0;
    end
  end
endmodule

// File: rtl/sat_alu_chk.sv
module sat_alu_chk #(
  parameter int W = 32
) (
  input logic         clk,
  input logic         rst,
  input logic         in_valid,
  input logic [31:0]  instr,
  input logic         cond_pass,
  input logic         flag_clr,
  input logic         out_valid,
  input logic         wr_en,
  input logic [W-1:0] result,
  input logic         q_flag
);
  logic runs;
  assign runs = in_valid && ((instr[31:28] == 4'hE) || cond_pass);

  p_slot_follows_r9: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  p_idle_slot_r9: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !wr_en));
  p_reset_clears_r10: assert property (@(posedge clk)
    rst |=> (!out_valid && !wr_en && !q_flag && result == '0));
  p_flag_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    (q_flag && !flag_clr) |=> q_flag);
  p_flag_needs_exec_r6: assert property (@(posedge clk) disable iff (rst)
    (!q_flag && !runs) |=> !q_flag);
  p_skip_no_write_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && !runs) |=> !wr_en);
  p_skip_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (!runs && !flag_clr) |=> ($stable(q_flag) && $stable(result)));
  p_write_needs_valid_r7: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> out_valid);
endmodule

bind sat_alu sat_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
  .cond_pass(cond_pass), .flag_clr(flag_clr), .out_valid(out_valid),
  .wr_en(wr_en), .result(result), .q_flag(q_flag)
);

// File: tb/sat_alu_tb.sv
module sat_alu_tb;
  logic        clk = 0;
  logic        rst = 1;
  logic        in_valid = 0;
  logic [31:0] instr = '0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic        cond_pass = 0;
  logic        flag_clr = 0;
  logic        out_valid, wr_en, q_flag;
  logic [3:0]  rd_idx;
  logic [31:0] result;

  always #2.5 clk = ~clk;

  sat_alu u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .instr(instr),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .cond_pass(cond_pass),
    .flag_clr(flag_clr), .out_valid(out_valid), .wr_en(wr_en),
    .rd_idx(rd_idx), .result(result), .q_flag(q_flag)
  );

  typedef struct packed {
    logic        we;
    logic [3:0]  rd;
    logic [31:0] res;
    logic        q;
    logic [31:0] tag;
  } exp_t;

  exp_t        sb[$];
  int          n_tests = 0;
  int          n_fail  = 0;
  bit          done    = 0;
  logic [31:0] m_res   = '0;
  logic        m_q     = 0;

  localparam longint MAXL = 64'sd2147483647;
  localparam longint MINL = -64'sd2147483648;

  function automatic longint clampv(input longint v, inout bit s);
    if (v > MAXL) begin s = 1; return MAXL; end
    if (v < MINL) begin s = 1; return MINL; end
    return v;
  endfunction

  task automatic check(input string req, input bit ok, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input logic [1:0] op, input logic [3:0] cc,
                       input bit pass, input bit clr, input logic [3:0] rd,
                       input string req);
    bit     s = 0;
    longint d, t;
    bit     ex;
    exp_t   e;
    @(negedge clk);
    in_valid  = 1;
    instr     = '0;
    instr[31:28] = cc;
    instr[22:21] = op;
    instr[15:12] = rd;
    opnd_a = a; opnd_b = b; cond_pass = pass; flag_clr = clr;
    d = longint'($signed(b));
    if (op[1]) d = clampv(d * 2, s);
    t = op[0] ? longint'($signed(a)) - d : longint'($signed(a)) + d;
    t = clampv(t, s);
    ex = (cc == 4'hE) || pass;
    if (ex) m_res = t[31:0];
    if (ex && s) m_q = 1;
    else if (clr) m_q = 0;
    e.we = ex; e.rd = rd; e.res = m_res; e.q = m_q;
    e.tag = 32'(req.atoi());
    e.tag = {req.getc(0), req.len() > 1 ? req.getc(1) : 8'd32,
             req.len() > 2 ? req.getc(2) : 8'd32, 8'd32};
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    in_valid = 0; flag_clr = 0; cond_pass = 0;
    repeat (n - 1) @(negedge clk);
  endtask

  always @(posedge clk) begin
    #1;
    if (!rst && out_valid) begin
      exp_t  e;
      string r;
      if (sb.size() == 0) begin
        check("R9", 0, "unexpected out_valid", 32'd1, 32'd0);
      end else begin
        e = sb.pop_front();
        r = $sformatf("%s", e.tag);
        check(r, wr_en == e.we, "wr_en", 32'(wr_en), 32'(e.we));
        check(r, result == e.res, "result", result, e.res);
        check("R6", q_flag == e.q, "q_flag", 32'(q_flag), 32'(e.q));
        check("R9", rd_idx == e.rd, "rd_idx", 32'(rd_idx), 32'(e.rd));
      end
    end
  end

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    check("R9", 0, "watchdog expired", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10", out_valid == 0, "out_valid after reset", 32'(out_valid), 0);
    check("R10", wr_en == 0, "wr_en after reset", 32'(wr_en), 0);
    check("R10", q_flag == 0, "q_flag after reset", 32'(q_flag), 0);
    check("R10", result == 0, "result after reset", result, 0);
    rst = 0;

    issue(32'd5, 32'd7, 2'b00, 4'hE, 0, 0, 4'd1, "R1");
    issue(32'hFFFFFFFF, 32'hFFFFFFFF, 2'b00, 4'hE, 0, 0, 4'd2, "R1");
    issue(32'd10, 32'd3, 2'b01, 4'hE, 0, 0, 4'd3, "R2");
    issue(32'd0, 32'hFFFFFFFF, 2'b01, 4'hE, 0, 0, 4'd4, "R2");
    issue(32'd100, 32'd21, 2'b10, 4'hE, 0, 0, 4'd5, "R3");
    issue(32'd100, 32'd21, 2'b11, 4'hE, 0, 0, 4'd6, "R4");
    idle(2);
    check("R6", q_flag == 0, "no saturation yet", 32'(q_flag), 0);
    issue(32'h7FFFFFFF, 32'd1, 2'b00, 4'hE, 0, 0, 4'd7, "R5");
    issue(32'd1, 32'd2, 2'b00, 4'hE, 0, 0, 4'd8, "R6");
    issue(32'h80000000, 32'hFFFFFFFF, 2'b00, 4'hE, 0, 0, 4'd9, "R5");
    issue(32'h80000000, 32'd1, 2'b01, 4'hE, 0, 0, 4'd10, "R5");
    issue(32'h7FFFFFFF, 32'hFFFFFFFF, 2'b01, 4'hE, 0, 0, 4'd11, "R5");
    issue(32'd0, 32'h80000000, 2'b01, 4'hE, 0, 1, 4'd12, "R11");
    issue(32'd3, 32'd4, 2'b00, 4'hE, 0, 1, 4'd13, "R11");
    issue(32'd3, 32'd4, 2'b00, 4'hE, 0, 0, 4'd13, "R11");
    issue(32'h80000000, 32'h80000000, 2'b10, 4'hE, 0, 0, 4'd14, "R3");
    issue(32'd0, 32'd0, 2'b00, 4'hE, 0, 1, 4'd0, "R11");
    issue(32'h7FFFFFFF, 32'h80000000, 2'b10, 4'hE, 0, 0, 4'd1, "R3");
    issue(32'd0, 32'd0, 2'b00, 4'hE, 0, 1, 4'd0, "R11");
    issue(32'h40000000, 32'd0, 2'b10, 4'hE, 0, 0, 4'd2, "R3");
    issue(32'hFFFFFFFF, 32'h40000000, 2'b10, 4'hE, 0, 0, 4'd3, "R3");
    issue(32'd0, 32'd0, 2'b00, 4'hE, 0, 1, 4'd0, "R11");
    issue(32'hFFFFFFFF, 32'hC0000000, 2'b11, 4'hE, 0, 0, 4'd4, "R4");
    issue(32'h80000000, 32'h00000001, 2'b11, 4'hE, 0, 0, 4'd5, "R4");
    issue(32'd0, 32'd0, 2'b00, 4'hE, 0, 1, 4'd0, "R11");
    issue(32'h00000000, 32'h80000000, 2'b11, 4'hE, 0, 0, 4'd6, "R4");
    issue(32'd0, 32'd0, 2'b00, 4'hE, 0, 1, 4'd0, "R11");
    issue(32'h7FFFFFFF, 32'h7FFFFFFF, 2'b00, 4'h0, 0, 0, 4'd7, "R8");
    issue(32'd9, 32'd9, 2'b01, 4'h1, 1, 0, 4'd8, "R7");
    issue(32'h7FFFFFFF, 32'd5, 2'b00, 4'hA, 0, 0, 4'd9, "R8");
    issue(32'hFFFFFFFF, 32'd0, 2'b00, 4'hF, 1, 0, 4'd10, "R7");
    issue(32'h7FFFFFFF, 32'd5, 2'b00, 4'h3, 1, 0, 4'd11, "R7");
    issue(32'd1, 32'd1, 2'b10, 4'h3, 0, 0, 4'd12, "R8");
    for (int i = 0; i < 24; i++) begin
      logic [31:0] c [4];
      c[0] = 32'h7FFFFFFF; c[1] = 32'h80000000; c[2] = 32'd0; c[3] = 32'hFFFFFFFF;
      issue(c[i % 4], c[(i / 4) % 4], 2'(i / 16 + (i % 3)), 4'hE, 0,
            (i % 5) == 0, 4'(i), "R5");
    end
    idle(3);
    check("R9", out_valid == 0, "out_valid idle", 32'(out_valid), 0);
    check("R9", wr_en == 0, "wr_en idle", 32'(wr_en), 0);
    check("R9", sb.size() == 0, "scoreboard drained", 32'(sb.size()), 0);
    finish_run();
  end
endmodule